// File: doc/BRIEF.md
# Five-Layer Overlay Pixel Mixer

The block sits between the per-window pixel fetch path and the panel output of a display controller. On every active pixel it receives the current screen coordinate together with one already unpacked 24-bit RGB pixel per window. It decides which windows cover that coordinate and composes them into one output colour. One cycle later it presents that colour with a valid flag.

Window 0 is an opaque base layer. Windows 1 to 4 stack above it in index order. Each of them carries a 4-bit alpha per colour channel and an optional colour key, which makes matching pixels see-through. A narrow write port loads each window's enable, rectangle corners, alpha and key. A write takes effect on the pixel that follows it.

Top module: `ovl_mixer`

## Requirements
- R1: While reset is low, and right after it, out_valid is 0 and out_rgb is 0. Reset disables every window, clears every key enable and key value, zeroes every corner, and sets every alpha nibble to 0xF.
- R2: out_valid equals pix_valid of the previous cycle. In a cycle whose previous pix_valid was 0, out_rgb is 0.
- R3: A window covers a pixel when left <= pix_x <= right and top <= pix_y <= bottom. Both corners are inclusive.
- R4: A window whose enable bit is 0 never changes the output.
- R5: Window 0, when it covers the pixel, contributes its pixel unchanged. Writes to its alpha, key value or key-enable bit have no effect.
- R6: Layers are applied in rising index order, so a covering window with a higher index is blended over the result of every lower one.
- R7: Each covering window w >= 1 updates every channel as floor((a*top + (15-a)*below)/15). Here a is that channel's alpha, top is the window's pixel channel and below is the result so far. With a=15 only the top is visible, and with a=0 the layer leaves the result unchanged.
- R8: When a window's key is enabled and its 24-bit pixel equals its key value, that window is skipped at that pixel.
- R9: When a window's key is disabled, its key value has no effect.
- R10: A pixel that no enabled window covers (and is not keyed out) is output as 24'h000000.
- R11: A register write happens when cfg_we=1. cfg_win selects the window (values >= 5 are ignored), and cfg_sel picks the register: 0 = control (bit 0 enable, bit 1 key enable), 1 = top-left (x in bits 10:0, y in bits 26:16), 2 = bottom-right (same layout), 3 = alpha (B in bits 3:0, G in 7:4, R in 11:8), 4 = key value (bits 23:0). Pixels and outputs pack R in bits 23:16, G in 15:8 and B in 7:0, and window w's pixel sits at pix_data[24w+23:24w].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 3 | Target window of the write |
| cfg_sel | input | 3 | Register select within the window |
| cfg_data | input | 32 | Write data |
| pix_valid | input | 1 | Coordinate and pixels are valid this cycle |
| pix_x | input | 11 | Current pixel column |
| pix_y | input | 11 | Current pixel row |
| pix_data | input | 120 | Fetched RGB pixel of each window, window 0 lowest |
| out_valid | output | 1 | Output colour valid |
| out_rgb | output | 24 | Composed RGB colour |

## Verification
The hardest case to reach is a colour-key hit. The window's fetched pixel must match its 24-bit key exactly, while the window is enabled, covers the coordinate and sits inside a stack of other covering layers. Uniform random colours would almost never produce that match. The random stimulus therefore draws each window's pixel from its current key value half of the time. It also confines all corners and coordinates to a 32 by 32 area, so rectangles overlap often and four- and five-deep stacks appear. Directed steps first fix exact inclusive edges, an exact blend value and the keyed and unkeyed cases.

// File: rtl/ovl_mixer.sv
module ovl_mixer #(
  parameter int NWIN = 5,
  parameter int CW   = 11,
  parameter int CHW  = 8,
  parameter int AW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_win,
  input  logic [2:0]              cfg_sel,
  input  logic [31:0]             cfg_data,
  input  logic                    pix_valid,
  input  logic [CW-1:0]           pix_x,
  input  logic [CW-1:0]           pix_y,
  input  logic [NWIN*3*CHW-1:0]   pix_data,
  output logic                    out_valid,
  output logic [3*CHW-1:0]        out_rgb
);
  localparam int PW   = 3 * CHW;
  localparam int PRW  = CHW + AW;
  localparam int AMAX = (1 << AW) - 1;

  logic [NWIN-1:0]               win_en, key_en, hit;
  logic [NWIN-1:0][CW-1:0]       lx, ty, rx, by;
  logic [NWIN-1:0][3*AW-1:0]     alpha;
  logic [NWIN-1:0][PW-1:0]       key_val;
  logic [PW-1:0]                 mix;

  wire upper = cfg_win != '0;

  function automatic logic [CHW-1:0] blend(input logic [AW-1:0] a,
                                           input logic [CHW-1:0] t,
                                           input logic [CHW-1:0] b);
    logic [PRW-1:0] s;
    s = PRW'(a) * PRW'(t) + PRW'(AW'(AMAX) - a) * PRW'(b);
    return CHW'(s / PRW'(AMAX));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_en  <= '0;
      key_en  <= '0;
      lx      <= '0;
      ty      <= '0;
      rx      <= '0;
      by      <= '0;
      alpha   <= '1;
      key_val <= '0;
    end else if (cfg_we && int'(cfg_win) < NWIN) begin
      case (cfg_sel)
        3'd0: begin
          win_en[cfg_win] <= cfg_data[0];
          if (upper) key_en[cfg_win] <= cfg_data[1];
        end
        3'd1: begin
          lx[cfg_win] <= cfg_data[CW-1:0];
          ty[cfg_win] <= cfg_data[16+:CW];
        end
        3'd2: begin
          rx[cfg_win] <= cfg_data[CW-1:0];
          by[cfg_win] <= cfg_data[16+:CW];
        end
        3'd3: if (upper) alpha[cfg_win] <= cfg_data[3*AW-1:0];
        3'd4: if (upper) key_val[cfg_win] <= cfg_data[PW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int w = 0; w < NWIN; w++)
      hit[w] = win_en[w] &&
               pix_x >= lx[w] && pix_x <= rx[w] &&
               pix_y >= ty[w] && pix_y <= by[w] &&
               !(key_en[w] && pix_data[w*PW +: PW] == key_val[w]);
  end

  always_comb begin
    mix = '0;
    if (hit[0]) mix = pix_data[0 +: PW];
    for (int w = 1; w < NWIN; w++)
      if (hit[w])
        for (int c = 0; c < 3; c++)
          mix[c*CHW +: CHW] = blend(alpha[w][c*AW +: AW],
                                    pix_data[w*PW + c*CHW +: CHW],
                                    mix[c*CHW +: CHW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      out_rgb   <= pix_valid ? mix : '0;
    end
  end
endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk #(
  parameter int NWIN = 5,
  parameter int CHW  = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           pix_valid,
  input logic [NWIN*3*CHW-1:0]          pix_data,
  input logic                           out_valid,
  input logic [3*CHW-1:0]               out_rgb,
  input logic [NWIN-1:0]                win_en,
  input logic [NWIN-1:0]                key_en,
  input logic [NWIN-1:0][3*CHW-1:0]     key_val
);
  localparam int PW = 3 * CHW;
  localparam logic [NWIN-1:0] TOP_ONLY  = {1'b1, {(NWIN-1){1'b0}}};
  localparam logic [NWIN-1:0] BASE_ONLY = {{(NWIN-1){1'b0}}, 1'b1};

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!out_valid && out_rgb == '0); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid); // R2

  AST_IDLE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && out_rgb == '0)); // R2

  AST_ALL_OFF_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && win_en == '0) |=> out_rgb == '0); // R4

  AST_BASE_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && win_en == BASE_ONLY) |=>
      (out_rgb == $past(pix_data[PW-1:0]) || out_rgb == '0)); // R5

  AST_TOP_KEYED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && win_en == TOP_ONLY && key_en[NWIN-1] &&
     pix_data[(NWIN-1)*PW +: PW] == key_val[NWIN-1]) |=> out_rgb == '0); // R8
endmodule

bind ovl_mixer ovl_mixer_chk #(.NWIN(NWIN), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
  .out_valid(out_valid), .out_rgb(out_rgb), .win_en(win_en),
  .key_en(key_en), .key_val(key_val)
);

// File: tb/test_ovl_mixer.sv
module test_ovl_mixer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_win = '0;
  logic [2:0]   cfg_sel = '0;
  logic [31:0]  cfg_data = '0;
  logic         pix_valid = 1'b0;
  logic [10:0]  pix_x = '0;
  logic [10:0]  pix_y = '0;
  logic [119:0] pix_data = '0;
  logic         out_valid;
  logic [23:0]  out_rgb;

  int n_chk = 0;
  int n_fail = 0;

  logic        m_en [5];
  logic        m_ken [5];
  int          m_lx [5], m_ty [5], m_rx [5], m_by [5];
  logic [11:0] m_alpha [5];
  logic [23:0] m_key [5];

  ovl_mixer i_ovl_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_mix(input int x, input int y,
                                          input logic [119:0] pd);
    logic [23:0] acc = '0;
    for (int w = 0; w < 5; w++) begin
      logic [23:0] p = pd[w*24 +: 24];
      if (m_en[w] && x >= m_lx[w] && x <= m_rx[w] && y >= m_ty[w] &&
          y <= m_by[w] && !(m_ken[w] && p == m_key[w])) begin
        if (w == 0) acc = p;
        else
          for (int c = 0; c < 3; c++) begin
            int a = int'(m_alpha[w][c*4 +: 4]);
            int v = (a * int'(p[c*8 +: 8]) + (15 - a) * int'(acc[c*8 +: 8])) / 15;
            acc[c*8 +: 8] = 8'(v);
          end
      end
    end
    return acc;
  endfunction

  task automatic wr(input int w, input int sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_sel = 3'(sel); cfg_data = d;
    pix_valid = 1'b0;
    if (w < 5)
      case (sel)
        0: begin m_en[w] = d[0]; if (w != 0) m_ken[w] = d[1]; end
        1: begin m_lx[w] = int'(d[10:0]); m_ty[w] = int'(d[26:16]); end
        2: begin m_rx[w] = int'(d[10:0]); m_by[w] = int'(d[26:16]); end
        3: if (w != 0) m_alpha[w] = d[11:0];
        4: if (w != 0) m_key[w] = d[23:0];
        default: ;
      endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rect(input int w, input int l, input int t, input int r, input int b);
    wr(w, 1, {5'd0, 11'(t), 5'd0, 11'(l)});
    wr(w, 2, {5'd0, 11'(b), 5'd0, 11'(r)});
  endtask

  task automatic px(input int x, input int y, input logic [119:0] pd, input string req);
    logic [23:0] e;
    pix_valid = 1'b1; pix_x = 11'(x); pix_y = 11'(y); pix_data = pd;
    e = exp_mix(x, y, pd);
    @(negedge clk);
    check(out_valid && out_rgb == e, req, out_rgb, e);
  endtask

  function automatic logic [119:0] pk(input logic [23:0] p4, input logic [23:0] p3,
                                      input logic [23:0] p2, input logic [23:0] p1,
                                      input logic [23:0] p0);
    return {p4, p3, p2, p1, p0};
  endfunction

  initial begin
    logic [119:0] pd;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 5; w++) begin
      m_en[w] = 0; m_ken[w] = 0; m_lx[w] = 0; m_ty[w] = 0; m_rx[w] = 0;
      m_by[w] = 0; m_alpha[w] = 12'hFFF; m_key[w] = '0;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && out_rgb == '0, "R1 reset outputs", out_rgb, 24'h0);
    rst_n = 1'b1;
    @(negedge clk);
    pd = pk(24'h445566, 24'h334455, 24'h223344, 24'h112233, 24'hA1B2C3);
    px(0, 0, pd, "R1 nothing enabled after reset");
    check(out_rgb == 24'h0, "R10 uncovered black", out_rgb, 24'h0);

    pix_valid = 1'b0;
    @(negedge clk);
    check(!out_valid && out_rgb == '0, "R2 idle cycle", out_rgb, 24'h0);

    rect(0, 10, 20, 19, 29);
    px(12, 22, pd, "R4 disabled base has no effect");
    wr(0, 0, 32'h1);
    px(10, 20, pd, "R3 top-left corner inclusive");
    check(out_rgb == 24'hA1B2C3, "R3 base pixel at corner", out_rgb, 24'hA1B2C3);
    px(19, 29, pd, "R3 bottom-right corner inclusive");
    px(9, 20, pd, "R3 left of rectangle");
    px(20, 29, pd, "R3 right of rectangle");
    px(10, 19, pd, "R3 above rectangle");
    px(19, 30, pd, "R3 below rectangle");

    wr(0, 3, 32'h0);
    wr(0, 4, 32'hA1B2C3);
    wr(0, 0, 32'h3);
    px(15, 25, pd, "R5 base alpha and key writes ignored");
    check(out_rgb == 24'hA1B2C3, "R5 base stays opaque", out_rgb, 24'hA1B2C3);
    wr(7, 0, 32'h0);
    px(15, 25, pd, "R11 write to window 7 ignored");

    rect(2, 10, 20, 19, 29);
    wr(2, 0, 32'h1);
    rect(1, 10, 20, 19, 29);
    wr(1, 0, 32'h1);
    px(15, 25, pd, "R6 window 2 over 1 and 0");
    check(out_rgb == 24'h223344, "R6 top window shown", out_rgb, 24'h223344);

    pd = pk(24'h0, 24'h0, 24'hFFFFFF, 24'h000000, 24'hA1B2C3);
    wr(2, 3, 32'h08F);
    px(15, 25, pd, "R7 per-channel alpha 0/8/15");
    check(out_rgb == 24'h0088FF, "R7 exact blend", out_rgb, 24'h0088FF);

    wr(2, 4, 32'hFFFFFF);
    px(15, 25, pd, "R9 key disabled, value matches");
    check(out_rgb == 24'h0088FF, "R9 key value has no effect", out_rgb, 24'h0088FF);
    wr(2, 0, 32'h3);
    px(15, 25, pd, "R8 keyed pixel transparent");
    check(out_rgb == 24'h000000, "R8 shows window 1", out_rgb, 24'h000000);
    pd[71:48] = 24'hFFFFFE;
    px(15, 25, pd, "R8 non-matching pixel blends");
    wr(2, 0, 32'h0);
    px(15, 25, pd, "R4 window 2 disabled");

    for (int i = 0; i < 3000; i++) begin
      if (i % 6 == 0) begin
        int w = int'($urandom_range(0, 4));
        int s = int'($urandom_range(0, 4));
        logic [31:0] d = $urandom;
        if (s == 1 || s == 2) d = {5'd0, 11'($urandom_range(0, 31)), 5'd0, 11'($urandom_range(0, 31))};
        if (s == 0) d = {30'd0, 2'($urandom_range(0, 3))};
        wr(w, s, d);
      end
      for (int w = 0; w < 5; w++)
        pd[w*24 +: 24] = ($urandom_range(0, 1) == 1) ? m_key[w] : 24'($urandom);
      px(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), pd,
         "R7 random stack (R6 R8 R3)");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule